// File: doc/BRIEF.md
# Byte-Counted Input Fetch Unit

This unit supplies a decoder core with compressed image bytes read from memory. It keeps a current read address and a remaining byte count; both can be loaded by the host. While bytes remain, the unit fetches one byte per request. Requests go out on a request/acknowledge memory port. The unit keeps the returned bytes in a small buffer and offers them to the decoder on a valid/ready stream.

If the count runs out while the decoder has not yet reported completion, the unit stops and raises an empty flag, together with a one-cycle event pulse. The host then loads a fresh address and count and writes a one to the flag to clear it. Fetching then continues from the new address. A soft reset aborts any request in flight and discards buffered bytes. It leaves the address and count registers as they are.

Host register offsets (4-bit word offsets):
- 0 is the control word. Bit 1 reads the empty flag, and writing a one to bit 1 clears it.
- 8 is the read address.
- 9 is the byte count.

Top module: `byte_fetch`

## Requirements
- R1: After reset, `mem_req`, `out_valid`, `empty_flag` and `empty_evt` are 0. Reading offsets 8 and 9 returns 0.
- R2: A host write to offset 8 loads the read address, and a write to offset 9 loads the byte count. Both read back unchanged on `host_rdata`. A host write takes precedence over an update from a fetch in the same cycle.
- R3: A request is raised with `mem_addr` equal to the read address. Both `mem_req` and `mem_addr` hold until the cycle in which `mem_ack` is seen.
- R4: Each acknowledged request adds one to the read address and subtracts one from the count. Bytes reach the decoder in fetch order, carrying the data returned for consecutive addresses.
- R5: No request is issued while the count is zero, the empty flag is set, or completion has been reported since the last soft reset.
- R6: When an acknowledge takes the count from 1 to 0 and completion has not been reported, `empty_flag` sets and `empty_evt` pulses for exactly one cycle.
- R7: If `dec_done` is high in the cycle the count reaches zero, or was high at any point earlier, the empty flag is not raised.
- R8: Writing offset 0 with bit 1 set clears the empty flag. Fetching then resumes from the newly loaded address.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R10: A soft reset drops `mem_req` and `out_valid` in the following cycle, discards an acknowledge arriving in the same cycle, and clears the empty flag and the completion record.
- R11: A request is only issued when the buffer has a free entry. With the decoder stalled, at most `BUF_DEPTH` bytes are fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous abort of fetching and buffered data |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | RA_W | Host write word offset |
| host_wdata | input | HW | Host write data |
| host_raddr | input | RA_W | Host read word offset |
| host_rdata | output | HW | Host read data (combinational) |
| dec_done | input | 1 | Decoder reports the image is complete |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | AW | Byte address of the request |
| mem_ack | input | 1 | Memory acknowledge, data valid |
| mem_rdata | input | 8 | Returned byte |
| out_valid | output | 1 | Byte available to decoder |
| out_data | output | 8 | Byte to decoder |
| out_ready | input | 1 | Decoder accepts byte |
| empty_flag | output | 1 | Count exhausted before completion |
| empty_evt | output | 1 | One-cycle pulse when the flag sets |

## Verification
A wrong address or count register shows at the ports within one request. The next `mem_addr` is wrong, the byte returned to the decoder differs from the scoreboard, and a readback of offset 8 or 9 disagrees. A wrong empty decision shows in the cycle after the last acknowledge, as a missing or spurious flag and event, or as a request issued when it should not be. A corrupt buffer level or pointer shows at the next transfer as an out-of-order byte, as a byte lost under backpressure, or as more fetches than buffer entries while the decoder is stalled.

// File: rtl/bfetch_pkg.sv
package bfetch_pkg;
   localparam int unsigned OFS_CTRL  = 0;
   localparam int unsigned OFS_ADDR  = 8;
   localparam int unsigned OFS_COUNT = 9;
   localparam int unsigned CTRL_CLR_BIT = 1;

   typedef enum logic {
      REQ_IDLE = 1'b0,
      REQ_WAIT = 1'b1
   } req_state_e;
endpackage

// File: rtl/bfetch_regs.sv
module bfetch_regs #(
   parameter int unsigned AW   = 32,
   parameter int unsigned CW   = 32,
   parameter int unsigned HW   = 32,
   parameter int unsigned RA_W = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          host_we,
   input  logic [RA_W-1:0] host_waddr,
   input  logic [HW-1:0] host_wdata,
   input  logic [RA_W-1:0] host_raddr,
   output logic [HW-1:0] host_rdata,
   input  logic          dec_done,
   input  logic          take,
   output logic [AW-1:0] addr_q,
   output logic [CW-1:0] cnt_q,
   output logic          flag_q,
   output logic          evt_q,
   output logic          done_q
);
   import bfetch_pkg::*;

   logic wr_ctrl, wr_addr, wr_cnt, last_byte, raise;

   always_comb begin
      wr_ctrl   = host_we && (host_waddr == RA_W'(OFS_CTRL));
      wr_addr   = host_we && (host_waddr == RA_W'(OFS_ADDR));
      wr_cnt    = host_we && (host_waddr == RA_W'(OFS_COUNT));
      last_byte = take && (cnt_q == CW'(1)) && !wr_cnt;
      raise     = last_byte && !dec_done && !done_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_addr)   addr_q <= host_wdata[AW-1:0];
         else if (take) addr_q <= addr_q + AW'(1);
         if (wr_cnt)    cnt_q  <= host_wdata[CW-1:0];
         else if (take) cnt_q  <= cnt_q - CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         evt_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (soft_rst) begin
         flag_q <= 1'b0;
         evt_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         evt_q <= raise;
         if (dec_done) done_q <= 1'b1;
         if (raise) flag_q <= 1'b1;
         else if (wr_ctrl && host_wdata[CTRL_CLR_BIT]) flag_q <= 1'b0;
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_raddr == RA_W'(OFS_ADDR))       host_rdata = HW'(addr_q);
      else if (host_raddr == RA_W'(OFS_COUNT)) host_rdata = HW'(cnt_q);
      else if (host_raddr == RA_W'(OFS_CTRL))  host_rdata[CTRL_CLR_BIT] = flag_q;
   end
endmodule

// File: rtl/bfetch_req.sv
module bfetch_req #(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          can_issue,
   input  logic [AW-1:0] addr_in,
   input  logic          mem_ack,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic          take
);
   import bfetch_pkg::*;

   req_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= REQ_IDLE;
         mem_addr <= '0;
      end else if (soft_rst) begin
         state_q <= REQ_IDLE;
      end else begin
         case (state_q)
            REQ_IDLE: if (can_issue) begin
               state_q  <= REQ_WAIT;
               mem_addr <= addr_in;
            end
            REQ_WAIT: if (mem_ack) state_q <= REQ_IDLE;
            default:  state_q <= REQ_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req = (state_q == REQ_WAIT);
      take    = mem_req && mem_ack && !soft_rst;
   end
endmodule

// File: rtl/bfetch_buf.sv
module bfetch_buf #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned DW    = 8,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [DW-1:0]    push_data,
   input  logic             pop,
   output logic             valid,
   output logic [DW-1:0]    data,
   output logic [LVL_W-1:0] level
);
   generate
      if (DEPTH == 1) begin : g_single
         logic          full_q;
         logic [DW-1:0] data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               full_q <= 1'b0;
               data_q <= '0;
            end else if (flush) begin
               full_q <= 1'b0;
            end else begin
               full_q <= push || (full_q && !pop);
               if (push) data_q <= push_data;
            end
         end
         always_comb begin
            valid = full_q;
            data  = data_q;
            level = LVL_W'(full_q);
         end
      end else begin : g_ring
         logic [DW-1:0]    mem_q [DEPTH];
         logic [PTR_W-1:0] wr_q, rd_q;
         logic [LVL_W-1:0] lvl_q;

         function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
            return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_q  <= '0;
               rd_q  <= '0;
               lvl_q <= '0;
            end else if (flush) begin
               wr_q  <= '0;
               rd_q  <= '0;
               lvl_q <= '0;
            end else begin
               if (push) wr_q <= nxt(wr_q);
               if (pop)  rd_q <= nxt(rd_q);
               lvl_q <= lvl_q + LVL_W'(push) - LVL_W'(pop);
            end
         end

         always_ff @(posedge clk) begin
            if (push) mem_q[wr_q] <= push_data;
         end

         always_comb begin
            valid = (lvl_q != '0);
            data  = mem_q[rd_q];
            level = lvl_q;
         end
      end
   endgenerate
endmodule

// File: rtl/byte_fetch.sv
module byte_fetch #(
   parameter int unsigned AW        = 32,
   parameter int unsigned CW        = 32,
   parameter int unsigned HW        = 32,
   parameter int unsigned RA_W      = 4,
   parameter int unsigned BUF_DEPTH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            soft_rst,
   input  logic            host_we,
   input  logic [RA_W-1:0] host_waddr,
   input  logic [HW-1:0]   host_wdata,
   input  logic [RA_W-1:0] host_raddr,
   output logic [HW-1:0]   host_rdata,
   input  logic            dec_done,
   output logic            mem_req,
   output logic [AW-1:0]   mem_addr,
   input  logic            mem_ack,
   input  logic [7:0]      mem_rdata,
   output logic            out_valid,
   output logic [7:0]      out_data,
   input  logic            out_ready,
   output logic            empty_flag,
   output logic            empty_evt
);
   localparam int unsigned LVL_W = $clog2(BUF_DEPTH + 1);

   generate
      if (AW > HW || CW > HW) begin : g_bad_width
         $error("address and count must fit the host data width");
      end
      if (BUF_DEPTH < 1) begin : g_bad_depth
         $error("BUF_DEPTH must be at least 1");
      end
      if (RA_W < 4) begin : g_bad_ra
         $error("RA_W must cover offset 9");
      end
   endgenerate

   logic [AW-1:0]    addr_q;
   logic [CW-1:0]    cnt_q;
   logic             done_q;
   logic             take;
   logic             can_issue;
   logic [LVL_W-1:0] buf_level;
   logic             pop;

   bfetch_regs #(.AW(AW), .CW(CW), .HW(HW), .RA_W(RA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
      .host_raddr(host_raddr), .host_rdata(host_rdata),
      .dec_done(dec_done), .take(take),
      .addr_q(addr_q), .cnt_q(cnt_q), .flag_q(empty_flag),
      .evt_q(empty_evt), .done_q(done_q)
   );

   always_comb begin
      can_issue = (cnt_q != '0) && !empty_flag && !done_q && !dec_done
                  && !soft_rst && (buf_level < LVL_W'(BUF_DEPTH));
      pop       = out_valid && out_ready;
   end

   bfetch_req #(.AW(AW)) u_req (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .can_issue(can_issue), .addr_in(addr_q), .mem_ack(mem_ack),
      .mem_req(mem_req), .mem_addr(mem_addr), .take(take)
   );

   bfetch_buf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst),
      .push(take), .push_data(mem_rdata), .pop(pop),
      .valid(out_valid), .data(out_data), .level(buf_level)
   );
endmodule

// File: rtl/byte_fetch_chk.sv
module byte_fetch_chk #(
   parameter int unsigned AW        = 32,
   parameter int unsigned CW        = 32,
   parameter int unsigned RA_W      = 4,
   parameter int unsigned BUF_DEPTH = 4,
   localparam int unsigned LVL_W = $clog2(BUF_DEPTH + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            soft_rst,
   input logic            host_we,
   input logic [RA_W-1:0] host_waddr,
   input logic            mem_req,
   input logic [AW-1:0]   mem_addr,
   input logic            mem_ack,
   input logic            out_valid,
   input logic [7:0]      out_data,
   input logic            out_ready,
   input logic            empty_flag,
   input logic            empty_evt,
   input logic [CW-1:0]   cnt_q,
   input logic [LVL_W-1:0] buf_level
);
   logic cnt_wr;
   assign cnt_wr = host_we && (host_waddr == RA_W'(9));

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack && !soft_rst |=> mem_req && $stable(mem_addr));

   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && !soft_rst && !cnt_wr |=> cnt_q == $past(cnt_q) - CW'(1));

   p_no_req_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(cnt_q) != '0 && !$past(empty_flag));

   p_evt_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      empty_evt |-> empty_flag);

   p_evt_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      empty_evt |=> !empty_evt);

   p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !soft_rst |=> out_valid && $stable(out_data));

   p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !mem_req && !out_valid && !empty_flag);

   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      buf_level <= LVL_W'(BUF_DEPTH));
endmodule

bind byte_fetch byte_fetch_chk #(
   .AW(AW), .CW(CW), .RA_W(RA_W), .BUF_DEPTH(BUF_DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
   .host_we(host_we), .host_waddr(host_waddr),
   .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
   .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
   .empty_flag(empty_flag), .empty_evt(empty_evt),
   .cnt_q(cnt_q), .buf_level(buf_level)
);

// File: tb/byte_fetch_test.sv
module byte_fetch_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;
   localparam int LAT        = 2;
   localparam int WDOG       = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        host_we = 1'b0;
   logic [3:0]  host_waddr = '0;
   logic [31:0] host_wdata = '0;
   logic [3:0]  host_raddr = '0;
   logic [31:0] host_rdata;
   logic        dec_done = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_ready = 1'b0;
   logic        empty_flag;
   logic        empty_evt;

   byte_fetch #(.BUF_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
      .host_raddr(host_raddr), .host_rdata(host_rdata),
      .dec_done(dec_done), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
      .empty_flag(empty_flag), .empty_evt(empty_evt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int          checks = 0;
   int          bad = 0;
   int          evt_cnt = 0;
   int          acks = 0;
   int          done_at = 0;
   int          cycles = 0;
   int          lat_cnt = 0;
   bit          ready_off = 1'b0;
   bit          skip_hold = 1'b0;
   bit          finished = 1'b0;
   logic [7:0]  exp_q[$];
   logic [15:0] lfsr = 16'hACE1;
   logic        prev_v = 1'b0, prev_r = 1'b0;
   logic [7:0]  prev_d = '0;

   function automatic logic [7:0] mem_byte(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory responder: acknowledges LAT cycles after a request appears
   always @(negedge clk) begin
      cycles++;
      if (done_at == 0) dec_done = 1'b0;
      if (!mem_req) begin
         lat_cnt = 0;
         mem_ack = 1'b0;
      end else begin
         lat_cnt++;
         if (lat_cnt >= LAT) begin
            mem_ack   = 1'b1;
            mem_rdata = mem_byte(mem_addr);
            acks++;
            if (done_at != 0 && acks == done_at) dec_done = 1'b1;
         end else begin
            mem_ack = 1'b0;
         end
      end
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = ready_off ? 1'b0 : (lfsr[0] | lfsr[3]);
      if (rst_n && !skip_hold && prev_v && !prev_r)
         chk(out_valid && out_data == prev_d, "R9 hold", {23'd0, out_valid, out_data}, {24'd1, prev_d});
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0)
            chk(1'b0, "R4 unexpected byte", {24'd0, out_data}, 32'hFFFF_FFFF);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(out_data == e, "R3/R4 byte order", {24'd0, out_data}, {24'd0, e});
         end
      end
      if (empty_evt) evt_cnt++;
      prev_v = out_valid;
      prev_r = out_ready;
      prev_d = out_data;
   end

   // watchdog
   always @(posedge clk) begin
      if (cycles > WDOG && !finished) begin
         finished = 1'b1;
         chk(1'b0, "watchdog", cycles, WDOG);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   task automatic host_write(input logic [3:0] ofs, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_waddr = ofs; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_read(input logic [3:0] ofs, output logic [31:0] d);
      host_raddr = ofs;
      #1;
      d = host_rdata;
   endtask

   task automatic load(input logic [31:0] a, input int n);
      host_write(4'd8, a);
      host_write(4'd9, n);
      for (int i = 0; i < n; i++) exp_q.push_back(mem_byte(a + i));
   endtask

   task automatic wait_flag(input string req);
      int t = 0;
      while (!empty_flag && t < 2000) begin @(negedge clk); t++; end
      chk(empty_flag, req, {31'd0, empty_flag}, 1);
   endtask

   task automatic drain(input string req);
      int t = 0;
      while (exp_q.size() != 0 && t < 2000) begin @(negedge clk); t++; end
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   task automatic no_req(input int n, input string req);
      bit seen = 1'b0;
      for (int i = 0; i < n; i++) begin @(negedge clk); if (mem_req) seen = 1'b1; end
      chk(!seen, req, {31'd0, seen}, 0);
   endtask

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!mem_req, "R1 mem_req", {31'd0, mem_req}, 0);
      chk(!out_valid, "R1 out_valid", {31'd0, out_valid}, 0);
      chk(!empty_flag && !empty_evt, "R1 flag", {30'd0, empty_flag, empty_evt}, 0);
      host_read(4'd8, rd); chk(rd == 0, "R1 addr", rd, 0);
      host_read(4'd9, rd); chk(rd == 0, "R1 count", rd, 0);

      // R2 readback, count 0 so nothing is fetched
      host_write(4'd8, 32'h1234_5678);
      host_read(4'd8, rd); chk(rd == 32'h1234_5678, "R2 addr readback", rd, 32'h1234_5678);
      no_req(5, "R5 count zero");

      // R4/R6 basic run until exhausted
      load(32'h0000_0100, 5);
      wait_flag("R6 flag after exhaustion");
      drain("R4 all bytes delivered");
      chk(evt_cnt == 1, "R6 event count", evt_cnt, 1);
      host_read(4'd8, rd); chk(rd == 32'h105, "R4 addr advanced", rd, 32'h105);
      host_read(4'd9, rd); chk(rd == 0, "R4 count zero", rd, 0);
      host_read(4'd0, rd); chk(rd == 32'h2, "R6 flag readback", rd, 32'h2);
      no_req(8, "R5 flag set");

      // R8 reload, stay stalled until clear, then resume
      host_write(4'd8, 32'h0000_2000);
      host_write(4'd9, 3);
      host_read(4'd9, rd); chk(rd == 3, "R2 count readback", rd, 3);
      no_req(8, "R5 flag still set");
      for (int i = 0; i < 3; i++) exp_q.push_back(mem_byte(32'h2000 + i));
      host_write(4'd0, 32'h2);
      wait_flag("R8 resumed and exhausted again");
      drain("R8 resumed bytes");
      chk(evt_cnt == 2, "R8 event count", evt_cnt, 2);
      host_read(4'd8, rd); chk(rd == 32'h2003, "R8 addr", rd, 32'h2003);

      // R7 completion on the same cycle as the last byte
      host_write(4'd0, 32'h2);
      done_at = acks + 4;
      load(32'h0000_0300, 4);
      drain("R7 bytes");
      repeat (10) @(negedge clk);
      chk(!empty_flag, "R7 no flag with done", {31'd0, empty_flag}, 0);
      chk(evt_cnt == 2, "R7 no event", evt_cnt, 2);
      load(32'h0000_0400, 2);
      no_req(8, "R5 done seen");
      exp_q.delete();
      done_at = 0;
      host_write(4'd9, 0);
      @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;

      // R11 backpressure bound
      ready_off = 1'b1;
      load(32'h0000_0500, 10);
      repeat (40) @(negedge clk);
      host_read(4'd9, rd); chk(rd == 10 - DEPTH, "R11 fetched only depth", rd, 10 - DEPTH);
      chk(!mem_req, "R11 no request when full", {31'd0, mem_req}, 0);
      ready_off = 1'b0;
      wait_flag("R11 flag after drain");
      drain("R11 bytes");
      host_write(4'd0, 32'h2);

      // R10 soft reset during an outstanding request with buffered bytes
      ready_off = 1'b1;
      load(32'h0000_0600, 8);
      begin
         int t = 0;
         while (!(out_valid && mem_req && lat_cnt < LAT - 1) && t < 500) begin @(negedge clk); t++; end
      end
      skip_hold = 1'b1;
      soft_rst = 1'b1;
      host_we = 1'b1; host_waddr = 4'd9; host_wdata = 0;
      @(negedge clk);
      soft_rst = 1'b0;
      host_we = 1'b0;
      exp_q.delete();
      chk(!mem_req, "R10 request dropped", {31'd0, mem_req}, 0);
      chk(!out_valid, "R10 buffer flushed", {31'd0, out_valid}, 0);
      begin
         bit seen = 1'b0;
         for (int i = 0; i < 10; i++) begin @(negedge clk); if (out_valid || mem_req) seen = 1'b1; end
         chk(!seen, "R10 nothing after abort", {31'd0, seen}, 0);
      end
      skip_hold = 1'b0;
      ready_off = 1'b0;

      repeat (5) @(negedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule